// File: doc/BRIEF.md
# Dual-Edge Timestamp Event Pairer

This block sits behind one time-to-digital converter channel whose trigger line carries two rising edges per detector hit. The first edge marks when the particle arrived. The second edge marks the moment the energy discriminator dropped back below its threshold. Each incoming record holds a coarse counter value, a 5-bit fine code and a one-bit flag. Together the coarse value and the fine code form a timestamp in 50 ps bins. The flag is the state of the delayed energy trigger, sampled when the edge was latched. A flag of 0 marks an arrival (time) edge. A flag of 1 marks an energy edge.

The block keeps the most recent time edge as a pending hit. When an energy edge follows, it emits one event. The event carries the arrival timestamp and the pulse width, which is the energy timestamp minus the arrival timestamp. The subtraction wraps over the full timestamp range.

Some hits never reach the energy threshold, so no energy edge follows them. These are overwritten by the next time edge and never appear at the output. An energy edge that finds no live pending hit is discarded and counted as an orphan. A pending hit is also discarded when its width exceeds a programmable limit.

Records arrive on a valid/ready stream and events leave on a valid/ready stream. The output is one register stage. While that register holds an event the consumer has not taken, `in_ready` is low, so the producer must hold its record stable. A record is taken on any clock edge where both `in_valid` and `in_ready` are high. An event is delivered on any clock edge where both `out_valid` and `out_ready` are high.

Top module: `tstamp_event_pairer`

## Requirements
- R1: After reset, `out_valid` is 0, `orphan_count` is 0, `in_ready` is 1, and no hit is pending.
- R2: An accepted record with `in_eflag`=0 is a time edge, and one with `in_eflag`=1 is an energy edge. A time edge followed by an energy edge raises `out_valid` in the cycle after the energy edge is accepted. The event carries the time edge's coarse and fine values and `out_width` = (coarse_e·32+fine_e) − (coarse_t·32+fine_t).
- R3: The width is computed modulo 2^(CW+5), so a coarse counter rollover between the two edges still gives the true width.
- R4: A time edge that arrives while a hit is pending replaces the pending hit. No event is produced and the orphan count does not change.
- R5: An energy edge that arrives with no pending hit produces no event and adds 1 to `orphan_count`. This includes a second energy edge after an event has already consumed the pending hit.
- R6: An energy edge whose width exceeds `max_width` produces no event, clears the pending hit and adds 1 to `orphan_count`. A width equal to `max_width` is accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, the event fields stay unchanged and `in_ready` is 0. A record presented during that stall is taken only after the event has been delivered.
- R8: `orphan_count` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Timestamp record offered |
| in_ready | output | 1 | Block can take a record this cycle |
| in_coarse | input | CW | Coarse counter value of the record |
| in_fine | input | FW | Fine interpolation code of the record |
| in_eflag | input | 1 | Sampled delayed-energy state (1 = energy edge) |
| max_width | input | CW+FW | Largest accepted pulse width in bins |
| out_valid | output | 1 | Event offered |
| out_ready | input | 1 | Consumer takes the event |
| out_coarse | output | CW | Arrival coarse value |
| out_fine | output | FW | Arrival fine code |
| out_width | output | CW+FW | Pulse width in bins |
| orphan_count | output | ECW | Saturating count of discarded energy edges |

## Verification
The bench targets several corner cases, each with a known failure it would expose:
- Rollover pairs, where the energy coarse value is below the arrival value. A design that does not wrap the subtraction, or that subtracts only the coarse parts, reports a huge or wrong width.
- The exact width limit and one bin past it. An off-by-one comparison keeps the wrong one of these two events.
- Two time edges in a row. A design that keeps the first edge instead of the second reports the older arrival time.
- Lone energy edges, and repeated energy edges after an event. These catch a pending hit that is not cleared after it is consumed.
- A long output stall with a record waiting on the input. This exposes an event that is overwritten or corrupted, and a waiting record that is lost or taken twice.
- Driving the counter past its top value. This shows whether it wraps instead of holding.

// File: rtl/tep_pkg.sv
package tep_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_ARM    = 2'd1,
    DEC_EMIT   = 2'd2,
    DEC_ORPHAN = 2'd3
  } tep_dec_e;
endpackage

// File: rtl/tep_pair_core.sv
module tep_pair_core
  import tep_pkg::*;
#(
  parameter int CW = 10,
  parameter int FW = 5,
  localparam int TW = CW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [CW-1:0] rec_coarse,
  input  logic [FW-1:0] rec_fine,
  input  logic          rec_eflag,
  input  logic [TW-1:0] max_width,
  output logic          emit,
  output logic          orphan,
  output logic [CW-1:0] emit_coarse,
  output logic [FW-1:0] emit_fine,
  output logic [TW-1:0] emit_width
);
  logic          pend_q;
  logic [TW-1:0] pend_ts_q;
  logic [TW-1:0] rec_ts;
  logic [TW-1:0] gap;
  tep_dec_e      dec;

  assign rec_ts = {rec_coarse, rec_fine};
  // modulo 2^TW difference handles coarse rollover
  assign gap    = rec_ts - pend_ts_q;

  always_comb begin
    dec = DEC_IDLE;
    if (acc) begin
      if (!rec_eflag)                       dec = DEC_ARM;
      else if (pend_q && gap <= max_width)  dec = DEC_EMIT;
      else                                  dec = DEC_ORPHAN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_ts_q <= '0;
    end else begin
      case (dec)
        DEC_ARM: begin
          pend_q    <= 1'b1;
          pend_ts_q <= rec_ts;
        end
        DEC_EMIT, DEC_ORPHAN: pend_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign emit        = (dec == DEC_EMIT);
  assign orphan      = (dec == DEC_ORPHAN);
  assign emit_coarse = pend_ts_q[TW-1:FW];
  assign emit_fine   = pend_ts_q[FW-1:0];
  assign emit_width  = gap;

  assert_clear_after_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> !pend_q);
  assert_arm_latest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rec_eflag) |=> (pend_q && pend_ts_q == $past(rec_ts)));
  assert_lone_energy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rec_eflag && !pend_q) |-> (orphan && !emit));
  assert_width_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (emit_width <= max_width));
endmodule

// File: rtl/tep_out_reg.sv
module tep_out_reg #(
  parameter int DW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          space,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  assign space     = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(data_q)));
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid_q || out_ready));
endmodule

// File: rtl/tep_sat_cnt.sv
module tep_sat_cnt #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [N-1:0] count
);
  localparam logic [N-1:0] TOP = '1;
  logic [N-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q == TOP) |=> (cnt_q == TOP));
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q));
endmodule

// File: rtl/tstamp_event_pairer.sv
module tstamp_event_pairer #(
  parameter int CW  = 10,
  parameter int FW  = 5,
  parameter int ECW = 8,
  localparam int TW = CW + FW,
  localparam int DW = CW + FW + TW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CW-1:0]  in_coarse,
  input  logic [FW-1:0]  in_fine,
  input  logic           in_eflag,
  input  logic [TW-1:0]  max_width,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CW-1:0]  out_coarse,
  output logic [FW-1:0]  out_fine,
  output logic [TW-1:0]  out_width,
  output logic [ECW-1:0] orphan_count
);
  logic          acc, emit, orphan, space;
  logic [CW-1:0] emit_coarse;
  logic [FW-1:0] emit_fine;
  logic [TW-1:0] emit_width;
  logic [DW-1:0] out_data;

  assign in_ready = space;
  assign acc      = in_valid && space;

  tep_pair_core #(.CW(CW), .FW(FW)) u_core (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .rec_coarse(in_coarse), .rec_fine(in_fine), .rec_eflag(in_eflag),
    .max_width(max_width),
    .emit(emit), .orphan(orphan),
    .emit_coarse(emit_coarse), .emit_fine(emit_fine), .emit_width(emit_width)
  );

  tep_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit),
    .load_data({emit_coarse, emit_fine, emit_width}),
    .space(space), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  tep_sat_cnt #(.N(ECW)) u_orphans (
    .clk(clk), .rst_n(rst_n), .inc(orphan), .count(orphan_count)
  );

  assign out_coarse = out_data[DW-1 -: CW];
  assign out_fine   = out_data[TW +: FW];
  assign out_width  = out_data[TW-1:0];

  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !acc);
endmodule

// File: tb/tstamp_event_pairer_bench.sv
module tstamp_event_pairer_bench;
  localparam int CW = 10, FW = 5, ECW = 8, TW = CW + FW;
  localparam int NV = 7;
  localparam int V_TC [0:NV-1] = '{5, 100, 1023, 10, 10, 1000, 1023};
  localparam int V_TF [0:NV-1] = '{3, 0, 30, 0, 0, 5, 0};
  localparam int V_EC [0:NV-1] = '{8, 100, 0, 72, 72, 1020, 61};
  localparam int V_EF [0:NV-1] = '{20, 0, 2, 16, 17, 31, 15};
  localparam int V_OK [0:NV-1] = '{1, 1, 1, 1, 0, 1, 1};
  localparam int V_W  [0:NV-1] = '{113, 0, 4, 2000, 0, 666, 1999};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_eflag = 0, out_ready = 1;
  logic [CW-1:0] in_coarse = '0;
  logic [FW-1:0] in_fine = '0;
  logic [TW-1:0] max_width = 15'd2000;
  logic in_ready, out_valid;
  logic [CW-1:0] out_coarse;
  logic [FW-1:0] out_fine;
  logic [TW-1:0] out_width;
  logic [ECW-1:0] orphan_count;

  int n_chk = 0, n_bad = 0, exp_orph = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tstamp_event_pairer #(.CW(CW), .FW(FW), .ECW(ECW)) u_tstamp_event_pairer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coarse(in_coarse), .in_fine(in_fine), .in_eflag(in_eflag),
    .max_width(max_width), .out_valid(out_valid), .out_ready(out_ready),
    .out_coarse(out_coarse), .out_fine(out_fine), .out_width(out_width),
    .orphan_count(orphan_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int c, input int f, input bit e);
    bit ok;
    in_valid = 1; in_coarse = CW'(c); in_fine = FW'(f); in_eflag = e;
    forever begin
      ok = in_ready;
      @(posedge clk); @(negedge clk);
      if (ok) break;
    end
    in_valid = 0;
  endtask

  task automatic chk_event(input string req, input int c, input int f, input int w);
    chk(out_valid == 1, req, int'(out_valid), 1);
    chk(out_coarse == CW'(c), req, int'(out_coarse), c);
    chk(out_fine == FW'(f), req, int'(out_fine), f);
    chk(out_width == TW'(w), req, int'(out_width), w);
  endtask

  task automatic chk_drop(input string req);
    chk(out_valid == 0, req, int'(out_valid), 0);
    chk(int'(orphan_count) == exp_orph, req, int'(orphan_count), exp_orph);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", int'(out_valid), 0);
    chk(orphan_count == 0, "R1", int'(orphan_count), 0);
    chk(in_ready == 1, "R1", int'(in_ready), 1);

    // Vector table: R2 pairing, R3 rollover, R6 width limit
    for (int i = 0; i < NV; i++) begin
      send(V_TC[i], V_TF[i], 0);
      send(V_EC[i], V_EF[i], 1);
      if (V_OK[i] != 0) chk_event("R2/R3/R6 vector", V_TC[i], V_TF[i], V_W[i]);
      else begin exp_orph++; chk_drop("R6 over limit"); end
    end

    // R6: pending cleared after an over-limit drop
    send(10, 0, 0);
    send(80, 0, 1);
    exp_orph++; chk_drop("R6 drop");
    send(81, 0, 1);
    exp_orph++; chk_drop("R6 pending cleared");

    // R4: second time edge replaces first
    send(1, 0, 0);
    send(2, 0, 0);
    chk_drop("R4 no event on retime");
    send(3, 0, 1);
    chk_event("R4", 2, 0, 32);

    // R5: lone energy edge, and repeat after event
    send(7, 7, 1);
    exp_orph++; chk_drop("R5 lone energy");
    send(20, 1, 0);
    send(20, 9, 1);
    chk_event("R5 setup", 20, 1, 8);
    send(21, 0, 1);
    exp_orph++; chk_drop("R5 second energy");

    // R7: back-pressure
    out_ready = 0;
    send(30, 4, 0);
    send(31, 4, 1);
    chk_event("R7 stalled event", 30, 4, 32);
    in_valid = 1; in_coarse = 10'd50; in_fine = 5'd0; in_eflag = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 0, "R7 in_ready low", int'(in_ready), 0);
      chk_event("R7 held", 30, 4, 32);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 0, "R7 delivered", int'(out_valid), 0);
    send(51, 0, 1);
    chk_event("R7 stalled record kept", 50, 0, 32);
    @(negedge clk);
    chk(orphan_count == ECW'(exp_orph), "R7 no double take", int'(orphan_count), exp_orph);

    // R8: saturation
    for (int k = 0; k < 260; k++) send(k % 1024, 0, 1);
    chk(orphan_count == 8'd255, "R8 saturate", int'(orphan_count), 255);
    chk(out_valid == 0, "R8 no event", int'(out_valid), 0);

    summary();
  end
endmodule